// File: doc/BRIEF.md
# Receive Slide Frame and Clock Aligner

This block brings a serial receiver into frame alignment. The receiver delivers parallel words, and the frame header must sit in a fixed field of each word. Until it does, the block asks the transceiver to slip by one bit with a single-cycle slide pulse. After each pulse it waits a programmable settling time before it looks at the received words again. Once the header has been seen on several valid words in a row, the link is declared aligned. A run of missed headers while aligned restarts the whole procedure through a transceiver reset.

There are three ways to reach alignment. In clock-shift mode the slide moves both the recovered clock and the data. The clock moves 2 UI on every second pulse, so the clock phase is fixed only if alignment needs an even number of pulses. An odd count therefore triggers a transceiver reset and a fresh attempt. In data-only mode only the data moves. The number of pulses used since the last reset is reported as the phase difference, in UI, between the transmit and receive user clocks. A phase control loop uses that value as its offset. In the fallback mode no slides are issued: the block requests resets until the header arrives already aligned.

The word stream carries a valid flag but has no back-pressure. The block never stalls the receiver. A word is examined in the cycle its valid is high, and it is ignored otherwise.

Top module: `rx_slide_aligner`

## Requirements
- R1: While `rst_n` is low, `slide`, `rst_req`, `aligned` and `ui_offset` are all 0.
- R2: `slide` is a one-cycle pulse. It is issued only after a valid word whose header is missing. With valid high every cycle, two consecutive pulses are exactly `settle_cycles`+2 cycles apart.
- R3: A header is present when `rx_word[W-1:W-HDR_W]` equals `hdr_pattern`. Words with `rx_valid` low are never examined, so they cause no slide and no alignment.
- R4: With `mode`=0 (clock shift), a header found after an odd number of slides since the last reset raises `rst_req` instead of alignment. Alignment is reached only on an even count, and `ui_offset` then reads 0.
- R5: With `mode`=1 (data only), while `aligned` is high `ui_offset` equals the number of slide pulses since the last reset request, up to W-1. At all other times it is 0.
- R6: With `mode`=2 or 3 (fallback), no slide is ever issued. A missing header on a valid word raises `rst_req`.
- R7: `aligned` rises only after LOCK_N consecutive valid words carry the header.
- R8: While aligned, LOSS_N consecutive valid words without the header drop `aligned` and raise `rst_req`. Fewer misses, followed by a hit, leave alignment intact.
- R9: A valid word without the header, seen after W-1 slides, raises `rst_req` instead of a further slide.
- R10: `rst_req` stays high until `rst_done` has been seen low and then high again. Every request clears the slide count, so the search after a reset starts from zero. After `rst_n` is released, no search starts before `rst_done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive user clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Received word is valid this cycle |
| rx_word | input | W | Received parallel word |
| hdr_pattern | input | HDR_W | Expected header value |
| mode | input | 2 | 0 clock shift, 1 data only, 2/3 fallback reset |
| settle_cycles | input | SET_W | Wait after each slide before checking again |
| rst_done | input | 1 | Transceiver reset complete |
| slide | output | 1 | One-cycle slip request to the transceiver |
| rst_req | output | 1 | Transceiver reset request |
| aligned | output | 1 | Frame alignment achieved |
| ui_offset | output | $clog2(W) | Slide count in UI (data-only mode, when aligned) |

## Verification
Several corner cases are driven against a behavioural transceiver model.

- **Odd-distance start in clock-shift mode.** A design that ignored parity would align with the clock off by 2 UI, and the bench would see no reset.
- **Header exactly W-1 slips away.** A wrap check that is off by one would reset one pulse too early.
- **Header never present before the first reset.** A design that failed to clear its count would report a stale 19 UI instead of 0.
- **Loss of alignment.** Misses one short of the loss threshold must not disturb alignment. The full run must trigger a reset, and the re-lock must report a fresh offset.
- **Gaps in `rx_valid`.** Lock must wait for the LOCK_N-th valid word, not count idle cycles.
- **Settle spacing.** The measured cycle distance between pulses would expose a miscounted timer.

// File: rtl/align_pkg.sv
package align_pkg;

  typedef enum logic [2:0] {
    ST_WAIT    = 3'd0,
    ST_SETTLE  = 3'd1,
    ST_HUNT    = 3'd2,
    ST_CONFIRM = 3'd3,
    ST_LOCKED  = 3'd4,
    ST_RST_LO  = 3'd5,
    ST_RST_HI  = 3'd6
  } align_state_t;

  localparam logic [1:0] MODE_CLK_SHIFT = 2'd0;
  localparam logic [1:0] MODE_DATA_ONLY = 2'd1;

endpackage

// File: rtl/hdr_match.sv
module hdr_match #(
  parameter int HDR_W = 4
) (
  input  logic             valid,
  input  logic [HDR_W-1:0] field,
  input  logic [HDR_W-1:0] pattern,
  output logic             hit,
  output logic             miss
);
  logic equal;
  assign equal = (field == pattern);
  assign hit   = valid & equal;
  assign miss  = valid & ~equal;
endmodule

// File: rtl/settle_timer.sv
module settle_timer #(
  parameter int SET_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [SET_W-1:0] load_val,
  output logic             expired
);
  logic [SET_W-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               remain <= '0;
    else if (load)            remain <= load_val;
    else if (remain != '0)    remain <= remain - 1'b1;
  end

  assign expired = (remain == '0);
endmodule

// File: rtl/align_ctrl.sv
module align_ctrl
  import align_pkg::*;
#(
  parameter int W      = 20,
  parameter int LOCK_N = 3,
  parameter int LOSS_N = 3,
  localparam int SC_W  = $clog2(W),
  localparam int LK_W  = $clog2(LOCK_N + 1),
  localparam int LS_W  = $clog2(LOSS_N + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hit,
  input  logic            miss,
  input  logic [1:0]      mode,
  input  logic            rst_done,
  input  logic            tmr_expired,
  output logic            tmr_load,
  output logic            slide,
  output logic            rst_req,
  output logic            aligned,
  output logic [SC_W-1:0] ui_offset
);
  align_state_t state, nxt;
  logic [SC_W-1:0] slide_cnt;
  logic [LK_W-1:0] good_cnt;
  logic [LS_W-1:0] bad_cnt;
  logic            slide_q;
  logic            do_slide, good_inc, bad_inc, bad_clr;
  logic            is_clk, is_data, is_fallback;

  assign is_clk      = (mode == MODE_CLK_SHIFT);
  assign is_data     = (mode == MODE_DATA_ONLY);
  assign is_fallback = mode[1];

  always_comb begin
    nxt      = state;
    do_slide = 1'b0;
    tmr_load = 1'b0;
    good_inc = 1'b0;
    bad_inc  = 1'b0;
    bad_clr  = 1'b0;
    case (state)
      ST_WAIT: begin
        if (rst_done) begin
          nxt      = ST_SETTLE;
          tmr_load = 1'b1;
        end
      end
      ST_SETTLE: begin
        if (tmr_expired) nxt = ST_HUNT;
      end
      ST_HUNT: begin
        if (hit) begin
          if (is_clk && slide_cnt[0]) nxt = ST_RST_LO;
          else if (LOCK_N == 1)       nxt = ST_LOCKED;
          else                        nxt = ST_CONFIRM;
        end else if (miss) begin
          if (is_fallback || slide_cnt == SC_W'(W - 1)) begin
            nxt = ST_RST_LO;
          end else begin
            do_slide = 1'b1;
            tmr_load = 1'b1;
            nxt      = ST_SETTLE;
          end
        end
      end
      ST_CONFIRM: begin
        if (hit) begin
          if (good_cnt == LK_W'(LOCK_N - 1)) nxt = ST_LOCKED;
          else                               good_inc = 1'b1;
        end else if (miss) begin
          nxt = ST_HUNT;
        end
      end
      ST_LOCKED: begin
        if (hit) begin
          bad_clr = 1'b1;
        end else if (miss) begin
          if (bad_cnt == LS_W'(LOSS_N - 1)) nxt = ST_RST_LO;
          else                              bad_inc = 1'b1;
        end
      end
      ST_RST_LO: begin
        if (!rst_done) nxt = ST_RST_HI;
      end
      ST_RST_HI: begin
        if (rst_done) begin
          nxt      = ST_SETTLE;
          tmr_load = 1'b1;
        end
      end
      default: nxt = ST_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_WAIT;
      slide_q   <= 1'b0;
      slide_cnt <= '0;
      good_cnt  <= '0;
      bad_cnt   <= '0;
    end else begin
      state   <= nxt;
      slide_q <= do_slide;

      if (state == ST_RST_LO || state == ST_RST_HI) slide_cnt <= '0;
      else if (do_slide)                            slide_cnt <= slide_cnt + 1'b1;

      if (state == ST_HUNT) good_cnt <= LK_W'(1);
      else if (good_inc)    good_cnt <= good_cnt + 1'b1;

      if (state != ST_LOCKED || bad_clr) bad_cnt <= '0;
      else if (bad_inc)                  bad_cnt <= bad_cnt + 1'b1;
    end
  end

  assign slide     = slide_q;
  assign rst_req   = (state == ST_RST_LO) || (state == ST_RST_HI);
  assign aligned   = (state == ST_LOCKED);
  assign ui_offset = (aligned && is_data) ? slide_cnt : '0;
endmodule

// File: rtl/rx_slide_aligner.sv
module rx_slide_aligner #(
  parameter int W      = 20,
  parameter int HDR_W  = 4,
  parameter int SET_W  = 8,
  parameter int LOCK_N = 3,
  parameter int LOSS_N = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rx_valid,
  input  logic [W-1:0]         rx_word,
  input  logic [HDR_W-1:0]     hdr_pattern,
  input  logic [1:0]           mode,
  input  logic [SET_W-1:0]     settle_cycles,
  input  logic                 rst_done,
  output logic                 slide,
  output logic                 rst_req,
  output logic                 aligned,
  output logic [$clog2(W)-1:0] ui_offset
);
  logic hit, miss, tmr_load, tmr_expired;
  logic unused_payload;

  assign unused_payload = ^rx_word[W-HDR_W-1:0];

  hdr_match #(.HDR_W(HDR_W)) u_match (
    .valid   (rx_valid),
    .field   (rx_word[W-1 -: HDR_W]),
    .pattern (hdr_pattern),
    .hit     (hit),
    .miss    (miss)
  );

  settle_timer #(.SET_W(SET_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (settle_cycles),
    .expired  (tmr_expired)
  );

  align_ctrl #(.W(W), .LOCK_N(LOCK_N), .LOSS_N(LOSS_N)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .hit         (hit),
    .miss        (miss),
    .mode        (mode),
    .rst_done    (rst_done),
    .tmr_expired (tmr_expired),
    .tmr_load    (tmr_load),
    .slide       (slide),
    .rst_req     (rst_req),
    .aligned     (aligned),
    .ui_offset   (ui_offset)
  );
endmodule

// File: rtl/rx_slide_aligner_chk.sv
module rx_slide_aligner_chk #(
  parameter int W      = 20,
  parameter int HDR_W  = 4,
  parameter int SET_W  = 8,
  parameter int LOCK_N = 3,
  localparam int SC_W  = $clog2(W),
  localparam int RUN_W = $clog2(LOCK_N + 1) + 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 rx_valid,
  input logic [W-1:0]         rx_word,
  input logic [HDR_W-1:0]     hdr_pattern,
  input logic [1:0]           mode,
  input logic [SET_W-1:0]     settle_cycles,
  input logic                 rst_done,
  input logic                 slide,
  input logic                 rst_req,
  input logic                 aligned,
  input logic [SC_W-1:0]      ui_offset
);
  logic [SC_W-1:0]  seen_slides;
  logic [SET_W:0]   gap;
  logic [RUN_W-1:0] run;
  logic             hdr_ok;

  assign hdr_ok = (rx_word[W-1 -: HDR_W] == hdr_pattern);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_slides <= '0;
      gap         <= '1;
      run         <= '0;
    end else begin
      if (rst_req)    seen_slides <= '0;
      else if (slide) seen_slides <= seen_slides + 1'b1;
      if (slide)          gap <= '0;
      else if (gap != '1) gap <= gap + 1'b1;
      if (rx_valid) begin
        if (!hdr_ok)        run <= '0;
        else if (run != '1) run <= run + 1'b1;
      end
    end
  end

  a_r2_slide_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    slide |=> !slide);
  a_r2_settle_gap: assert property (@(posedge clk) disable iff (!rst_n)
    slide |-> (gap > {1'b0, settle_cycles}));
  a_r4_even_clock_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (aligned && mode == 2'd0) |-> !seen_slides[0]);
  a_r5_ui_matches_slides: assert property (@(posedge clk) disable iff (!rst_n)
    (aligned && mode == 2'd1) |-> (ui_offset == seen_slides));
  a_r6_fallback_no_slide: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[1] && $past(mode[1])) |-> !slide);
  a_r7_lock_after_run: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aligned) |-> (run >= RUN_W'(LOCK_N)));
  a_r8_aligned_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    aligned |-> (!rst_req && !slide));
  a_r10_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req && !rst_done) |=> rst_req);
endmodule

bind rx_slide_aligner rx_slide_aligner_chk #(
  .W(W), .HDR_W(HDR_W), .SET_W(SET_W), .LOCK_N(LOCK_N)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_word(rx_word),
  .hdr_pattern(hdr_pattern), .mode(mode), .settle_cycles(settle_cycles),
  .rst_done(rst_done), .slide(slide), .rst_req(rst_req),
  .aligned(aligned), .ui_offset(ui_offset)
);

// File: tb/rx_slide_aligner_tb.sv
`timescale 1ns/1ps
module rx_slide_aligner_tb;
  localparam int W      = 20;
  localparam int HDR_W  = 4;
  localparam int SET_W  = 8;
  localparam int LOCK_N = 3;
  localparam int LOSS_N = 3;
  localparam int TGT    = 5;
  localparam int SETTLE = 6;
  localparam logic [HDR_W-1:0] HDR = 4'hA;
  localparam int NROWS  = 8;

  // mode, start offset, offset after reset, hide until reset, valid gaps,
  // expected slides, expected resets, expected ui, pad
  localparam logic [31:0] VEC [NROWS] = '{
    {2'd0, 5'd1,  5'd0, 1'b0, 1'b0, 6'd4,  3'd0, 5'd0,  4'd0},
    {2'd0, 5'd2,  5'd3, 1'b0, 1'b0, 6'd5,  3'd1, 5'd0,  4'd0},
    {2'd1, 5'd12, 5'd0, 1'b0, 1'b0, 6'd13, 3'd0, 5'd13, 4'd0},
    {2'd1, 5'd5,  5'd0, 1'b0, 1'b1, 6'd0,  3'd0, 5'd0,  4'd0},
    {2'd1, 5'd6,  5'd0, 1'b0, 1'b0, 6'd19, 3'd0, 5'd19, 4'd0},
    {2'd1, 5'd9,  5'd5, 1'b1, 1'b0, 6'd19, 3'd1, 5'd0,  4'd0},
    {2'd2, 5'd8,  5'd5, 1'b0, 1'b0, 6'd0,  3'd1, 5'd0,  4'd0},
    {2'd0, 5'd0,  5'd5, 1'b0, 1'b1, 6'd5,  3'd1, 5'd0,  4'd0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_valid = 1'b0;
  logic [W-1:0] rx_word = '0;
  logic [1:0] mode = 2'd0;
  logic rst_done = 1'b1;
  logic slide, rst_req, aligned;
  logic [$clog2(W)-1:0] ui_offset;

  always #2.5 clk = ~clk;

  rx_slide_aligner #(.W(W), .HDR_W(HDR_W), .SET_W(SET_W), .LOCK_N(LOCK_N), .LOSS_N(LOSS_N)) u_dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_word(rx_word),
    .hdr_pattern(HDR), .mode(mode), .settle_cycles(SET_W'(SETTLE)),
    .rst_done(rst_done), .slide(slide), .rst_req(rst_req),
    .aligned(aligned), .ui_offset(ui_offset)
  );

  int total = 0, bad = 0;
  int cyc = 0, pos = 0, ro = 0, busy = 0;
  int n_slides = 0, n_resets = 0, last_slide = -1, first_gap = -1;
  bit hide = 0, corrupt = 0, gaps = 0, valid_off = 0, prev_req = 0;

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // transceiver model, updated away from the active edge
  task automatic step();
    @(negedge clk);
    cyc++;
    if (slide) begin
      pos = (pos + 1) % W;
      n_slides++;
      if (last_slide >= 0 && first_gap < 0) first_gap = cyc - last_slide;
      last_slide = cyc;
    end
    if (rst_req && !prev_req) begin
      n_resets++;
      busy = 3;
      rst_done = 1'b0;
    end
    prev_req = rst_req;
    if (busy > 0) begin
      busy--;
      if (busy == 0) begin
        pos = ro;
        hide = 0;
        rst_done = 1'b1;
      end
    end
    rx_word  = {((pos == TGT) && !hide && !corrupt) ? HDR : ~HDR, cyc[W-HDR_W-1:0]};
    rx_valid = valid_off ? 1'b0 : (gaps ? cyc[0] : 1'b1);
  endtask

  task automatic start(logic [1:0] m, int p0, int r0, bit h, bit g);
    rst_n = 1'b0;
    mode = m; pos = p0; ro = r0; hide = h; gaps = g;
    busy = 0; rst_done = 1'b1; prev_req = 0; corrupt = 0;
    n_slides = 0; n_resets = 0; last_slide = -1; first_gap = -1;
    repeat (3) step();
    rst_n = 1'b1;
  endtask

  task automatic wait_lock();
    for (int k = 0; k < 3000 && !aligned; k++) step();
  endtask

  task automatic run_all();
    // R1: reset state
    start(2'd1, 0, 0, 0, 0);
    rst_n = 1'b0;
    step();
    chk("R1 slide", slide, 0);
    chk("R1 rst_req", rst_req, 0);
    chk("R1 aligned", aligned, 0);
    chk("R1 ui_offset", ui_offset, 0);

    for (int i = 0; i < NROWS; i++) begin
      logic [31:0] v;
      v = VEC[i];
      start(v[31:30], int'(v[29:25]), int'(v[24:20]), v[19], v[18]);
      wait_lock();
      // R4 R5 R6 R9: row outcome
      chk($sformatf("R7 row%0d aligned", i), aligned, 1);
      chk($sformatf("R4/R6/R9 row%0d slides", i), n_slides, int'(v[17:12]));
      chk($sformatf("R10 row%0d resets", i), n_resets, int'(v[11:9]));
      chk($sformatf("R5 row%0d ui", i), ui_offset, int'(v[8:4]));
      if (i == 2) chk("R2 slide spacing", first_gap, SETTLE + 2);
    end

    // R3 and R7: no valid words, then a lock built from separated valid words
    valid_off = 1;
    start(2'd1, TGT, TGT, 0, 0);
    repeat (40) step();
    chk("R3 no valid no slide", n_slides, 0);
    chk("R3 no valid no lock", aligned, 0);
    valid_off = 0;
    repeat (LOCK_N - 1) step();
    valid_off = 1;
    repeat (10) step();
    chk("R7 not locked before LOCK_N", aligned, 0);
    valid_off = 0;
    step();
    valid_off = 1;
    repeat (2) step();
    chk("R7 locked at LOCK_N", aligned, 1);
    valid_off = 0;

    // R8: short miss run tolerated, full run loses lock
    ro = TGT - 3;
    corrupt = 1;
    repeat (LOSS_N - 1) step();
    corrupt = 0;
    repeat (5) step();
    chk("R8 short miss keeps lock", aligned, 1);
    chk("R8 short miss no reset", n_resets, 0);
    corrupt = 1;
    repeat (LOSS_N) step();
    corrupt = 0;
    repeat (2) step();
    chk("R8 loss drops aligned", aligned, 0);
    chk("R10 request held during reset", rst_req, 1);
    chk("R8 loss requests reset", n_resets, 1);
    wait_lock();
    chk("R10 relock aligned", aligned, 1);
    chk("R10 count cleared ui", ui_offset, 3);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog R1 actual=timeout expected=finished");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule